// File: doc/BRIEF.md
# Bidirectional Port with Timer Pin Takeover

This block is a seven-pin general-purpose I/O port controlled over a byte-wide register bus. Two registers are exposed. An output value register holds a stored value for each pin. An output-enable register chooses whether each pin is driven or left as an input. Each pad is modelled as three separate signals: an input value, an output value and an output enable. The block drives the output value and the enable, and returns register reads.

Six of the pins can be handed to timer channels. Pins 3 to 0 belong to one timer and pins 5 and 4 to another. The timer logic is outside this block. It is represented by a two-bit mode selector per pin, plus a per-pin drive value and drive enable. A nonzero mode selector gives the timer full control of the pin's direction and value. Even then, the output-enable bit still decides what a read of the value register returns: the stored value or the live pin level. Pin 6 has no timer role.

Pad inputs pass through a synchronizer before they can be read. Pad outputs are registered, so every change to the pad drive lands exactly one clock after its cause.

Top module: `gpio_timer_port`

## Requirements
- R1: The value register is at bus address 0 and the enable register at bus address 1. Bits 6..0 map to pins 6..0. Bit 7 of both registers always reads 0. Reads of addresses 2 and 3 return 0. Reads are combinational from the address.
- R2: A bus write to address 1 stores bits 6..0 as the enable bits on that clock edge. The stored bits read back unchanged.
- R3: A cycle with synchronous reset high clears every enable bit. While reset is high and on the edge after, `pin_oe` is 0 on all pins.
- R4: Reset does not alter the stored output values. A write to address 0 issued while reset is high is ignored.
- R5: A read of address 0 returns, for each bit, the stored value where the enable bit is 1 and the synchronized pin level where it is 0.
- R6: When pin i (0 to 5) has a nonzero mode selector `tmr_els[2i+1:2i]`, `pin_out[i]` and `pin_oe[i]` equal `tmr_out[i]` and `tmr_oe[i]` one clock later, whatever its enable bit is.
- R7: A pin under timer control still uses its enable bit to choose its read-back source, exactly as in R5.
- R8: Pin 6 ignores its mode selector and is always driven by the port registers.
- R9: Writes to address 0 update the stored value even while the pin is an input or under timer control. The new value appears on `pin_out` once port control of the pin resumes.
- R10: A change on `pin_in` shows up in a read of address 0 after exactly two rising clock edges, and not after one.
- R11: A pin under port control has `pin_out` equal to its stored value and `pin_oe` equal to its enable bit, each registered one clock after the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 7 | Pad input levels |
| pin_out | output | 7 | Pad output values, registered |
| pin_oe | output | 7 | Pad output enables, registered |
| tmr_els | input | 14 | Two-bit mode selector per pin; nonzero hands the pin to a timer |
| tmr_out | input | 7 | Timer drive value per pin |
| tmr_oe | input | 7 | Timer drive enable per pin |

## Verification
The bench uses the default configuration: seven pins, a two-bit address, a two-stage synchronizer, and a takeover mask that covers pins 0 to 5. With only seven pins, every one of the 128 enable patterns can be swept against computed read-back values. A second full sweep covers all 128 ownership patterns, with varying nonzero selector codes, enable values and timer drives. Together these put each pin's read source and drive source, including the ignored selector on pin 6, fully within reach. Directed sequences then cover synchronizer latency, reset behaviour and the handback of a stored value when the timer releases a pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic val_we;
    logic oen_we;
  } reg_we_t;

  function automatic logic sel_claims(input logic [SEL_W-1:0] sel);
    return |sel;
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W    = 7,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int VAL_ADDR = 0,
  parameter int OEN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [PIN_W-1:0]  val_q,
  output logic [PIN_W-1:0]  oen_q
);
  reg_we_t we;
  logic    unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:PIN_W];

  always_comb begin
    we.val_we = bus_wr && (bus_addr == ADDR_W'(VAL_ADDR));
    we.oen_we = bus_wr && (bus_addr == ADDR_W'(OEN_ADDR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oen_q <= '0;
    end else if (we.oen_we) begin
      oen_q <= bus_wdata[PIN_W-1:0];
    end
  end

  // stored output values carry no reset
  always_ff @(posedge clk) begin
    if (!rst && we.val_we) begin
      val_q <= bus_wdata[PIN_W-1:0];
    end
  end

  a_r3_oen_cleared: assert property (@(posedge clk)
    rst |=> (oen_q == '0));

  a_r2_oen_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OEN_ADDR)) |=> (oen_q == $past(bus_wdata[PIN_W-1:0])));

  a_r9_val_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(VAL_ADDR)) |=> (val_q == $past(bus_wdata[PIN_W-1:0])));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int PIN_W  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_sync
);
  logic [PIN_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= pin_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_port_pkg::*;
#(
  parameter int               PIN_W    = 7,
  parameter logic [PIN_W-1:0] ALT_MASK = 7'b011_1111
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PIN_W-1:0]       val_q,
  input  logic [PIN_W-1:0]       oen_q,
  input  logic [SEL_W*PIN_W-1:0] tmr_els,
  input  logic [PIN_W-1:0]       tmr_out,
  input  logic [PIN_W-1:0]       tmr_oe,
  output logic [PIN_W-1:0]       pin_out,
  output logic [PIN_W-1:0]       pin_oe
);
  logic [PIN_W-1:0] owned;
  logic [PIN_W-1:0] nxt_out;
  logic [PIN_W-1:0] nxt_oe;

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    if (ALT_MASK[i]) begin : g_alt
      assign owned[i]   = sel_claims(tmr_els[SEL_W*i +: SEL_W]);
      assign nxt_out[i] = owned[i] ? tmr_out[i] : val_q[i];
      assign nxt_oe[i]  = owned[i] ? tmr_oe[i]  : oen_q[i];

      a_r6_timer_drive: assert property (@(posedge clk) disable iff (rst)
        owned[i] |=> (pin_out[i] == $past(tmr_out[i]) && pin_oe[i] == $past(tmr_oe[i])));
    end else begin : g_plain
      logic unused_alt;
      assign unused_alt = ^{tmr_els[SEL_W*i +: SEL_W], tmr_out[i], tmr_oe[i]};
      assign owned[i]   = 1'b0;
      assign nxt_out[i] = val_q[i];
      assign nxt_oe[i]  = oen_q[i];
    end

    a_r11_port_drive: assert property (@(posedge clk) disable iff (rst)
      !owned[i] |=> (pin_out[i] == $past(val_q[i]) && pin_oe[i] == $past(oen_q[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end

  a_r3_oe_low: assert property (@(posedge clk)
    rst |=> (pin_oe == '0));
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux #(
  parameter int PIN_W    = 7,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int VAL_ADDR = 0,
  parameter int OEN_ADDR = 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  val_q,
  input  logic [PIN_W-1:0]  oen_q,
  input  logic [PIN_W-1:0]  pin_sync,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [PIN_W-1:0] port_view;

  for (genvar i = 0; i < PIN_W; i++) begin : g_src
    assign port_view[i] = oen_q[i] ? val_q[i] : pin_sync[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(VAL_ADDR)) begin
      bus_rdata[PIN_W-1:0] = port_view;
    end else if (bus_addr == ADDR_W'(OEN_ADDR)) begin
      bus_rdata[PIN_W-1:0] = oen_q;
    end
  end
endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port
  import gpio_port_pkg::*;
#(
  parameter int               PIN_W       = 7,
  parameter int               ADDR_W      = 2,
  parameter int               DATA_W      = 8,
  parameter int               VAL_ADDR    = 0,
  parameter int               OEN_ADDR    = 1,
  parameter int               SYNC_STAGES = 2,
  parameter logic [PIN_W-1:0] ALT_MASK    = 7'b011_1111
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [PIN_W-1:0]       pin_in,
  output logic [PIN_W-1:0]       pin_out,
  output logic [PIN_W-1:0]       pin_oe,
  input  logic [SEL_W*PIN_W-1:0] tmr_els,
  input  logic [PIN_W-1:0]       tmr_out,
  input  logic [PIN_W-1:0]       tmr_oe
);
  logic [PIN_W-1:0] val_q;
  logic [PIN_W-1:0] oen_q;
  logic [PIN_W-1:0] pin_sync;

  gpio_regs #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VAL_ADDR(VAL_ADDR), .OEN_ADDR(OEN_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .val_q(val_q), .oen_q(oen_q)
  );

  gpio_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_pinmux #(.PIN_W(PIN_W), .ALT_MASK(ALT_MASK)) u_mux (
    .clk(clk), .rst(rst), .val_q(val_q), .oen_q(oen_q),
    .tmr_els(tmr_els), .tmr_out(tmr_out), .tmr_oe(tmr_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_readmux #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VAL_ADDR(VAL_ADDR), .OEN_ADDR(OEN_ADDR)
  ) u_rd (
    .bus_addr(bus_addr), .val_q(val_q), .oen_q(oen_q),
    .pin_sync(pin_sync), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/gpio_timer_port_test.sv
module gpio_timer_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [6:0]  pin_in = '0;
  logic [6:0]  pin_out;
  logic [6:0]  pin_oe;
  logic [13:0] tmr_els = '0;
  logic [6:0]  tmr_out = '0;
  logic [6:0]  tmr_oe = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_timer_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tmr_els(tmr_els),
    .tmr_out(tmr_out), .tmr_oe(tmr_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [6:0] view(input logic [6:0] oen, input logic [6:0] val, input logic [6:0] pin);
    return (oen & val) | (~oen & pin);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    repeat (3) tick();
    check("R3 oe during reset", {1'b0, pin_oe}, 8'h00);
    rst = 1'b0;
    rd(2'd1, v);
    check("R3 enable after reset", v, 8'h00);

    // R1 / R2 / R11 basic
    wr(2'd0, 8'h55);
    wr(2'd1, 8'h7F);
    tick();
    check("R11 pin_oe follows enable", {1'b0, pin_oe}, 8'h7F);
    check("R11 pin_out follows value", {1'b0, pin_out}, 8'h55);
    rd(2'd0, v);
    check("R5 read stored value", v, 8'h55);
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    check("R1 bit7 enable reads 0", v, 8'h7F);
    wr(2'd0, 8'hAA);
    rd(2'd0, v);
    check("R1 bit7 value reads 0", v, 8'h2A);
    rd(2'd2, v);
    check("R1 addr2 reads 0", v, 8'h00);
    rd(2'd3, v);
    check("R1 addr3 reads 0", v, 8'h00);
    wr(2'd1, 8'h19);
    rd(2'd1, v);
    check("R2 enable readback", v, 8'h19);

    // R4: reset keeps stored value, write during reset ignored
    rst = 1'b1;
    wr(2'd0, 8'h11);
    tick();
    check("R3 oe after reset", {1'b0, pin_oe}, 8'h00);
    rst = 1'b0;
    rd(2'd1, v);
    check("R3 enable cleared", v, 8'h00);
    wr(2'd1, 8'h7F);
    rd(2'd0, v);
    check("R4 value kept over reset", v, 8'h2A);

    // R5 sweep over every enable pattern
    for (int d = 0; d < 128; d++) begin
      logic [6:0] pv;
      logic [6:0] lv;
      pv = 7'((d * 37) ^ 8'h5A);
      lv = 7'(d * 11 + 3);
      pin_in = pv;
      wr(2'd0, {1'b0, lv});
      wr(2'd1, 8'(d));
      tick();
      rd(2'd0, v);
      check("R5 read source sweep", v, {1'b0, view(7'(d), lv, pv)});
      check("R11 oe sweep", {1'b0, pin_oe}, 8'(d));
      check("R11 out sweep", {1'b0, pin_out}, {1'b0, lv});
    end

    // R10 synchronizer latency
    wr(2'd1, 8'h00);
    pin_in = 7'h0F;
    repeat (3) tick();
    pin_in = 7'h70;
    tick();
    rd(2'd0, v);
    check("R10 one edge still old", v, 8'h0F);
    tick();
    rd(2'd0, v);
    check("R10 two edges new", v, 8'h70);

    // R6 / R7 / R8 ownership sweep
    pin_in = 7'h36;
    for (int m = 0; m < 128; m++) begin
      logic [6:0] own;
      logic [6:0] oen;
      logic [6:0] lv;
      logic [6:0] to;
      logic [6:0] te;
      for (int i = 0; i < 7; i++) begin
        tmr_els[2*i +: 2] = m[i] ? 2'((m + i) % 3 + 1) : 2'd0;
      end
      to  = 7'(m * 5);
      te  = 7'(~(m * 3));
      oen = 7'(m ^ 8'h2B);
      lv  = 7'(m * 9);
      tmr_out = to;
      tmr_oe  = te;
      own = 7'(m) & 7'h3F;
      wr(2'd0, {1'b0, lv});
      wr(2'd1, {1'b0, oen});
      tick();
      check("R6 R8 drive value", {1'b0, pin_out}, {1'b0, (own & to) | (~own & lv)});
      check("R6 R8 drive enable", {1'b0, pin_oe}, {1'b0, (own & te) | (~own & oen)});
      rd(2'd0, v);
      check("R7 read source under timer", v, {1'b0, view(oen, lv, 7'h36)});
    end

    // R9: value written while timer owns pin appears on release
    tmr_els = '0;
    tmr_els[1:0] = 2'd2;
    tmr_out = 7'h00;
    tmr_oe  = 7'h01;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    tick();
    check("R9 timer still drives pin0", {7'h0, pin_out[0]}, 8'h00);
    tmr_els = '0;
    wr(2'd1, 8'h01);
    tick();
    check("R9 stored value after release", {7'h0, pin_out[0]}, 8'h01);
    check("R9 enable after release", {7'h0, pin_oe[0]}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule